// File: doc/BRIEF.md
# Single-Register Shift and Rotate Execution Unit

This unit runs the single-register shift and rotate operations of a register machine. An operation is started with one strobe. The strobe carries an operation select, a 64-bit source operand, the old destination value, and the parts of a shift-amount address: a base field selector, the base register value and a 12-bit displacement. One clock later the unit returns, all registered, the value to write back, a 2-bit condition code, a flag saying whether that code should update the machine's condition state, and a valid pulse.

The shift count is the low six bits of an effective address. That address is the displacement alone when the base selector is zero. Otherwise it is the base value plus the displacement. Ten operations are supported: rotate left, logical left and right shifts, and arithmetic left and right shifts, each in a 32-bit and a 64-bit width. The arithmetic left shift never changes the operand's sign bit. It reports overflow through the condition code. The 32-bit forms replace only the low word of the destination. Fetch, decode, the register file, paired-register shifts and exception delivery lie outside this unit.

Top module: `shrot_unit`

## Requirements
- R1: The shift count is bits [5:0] of `disp` when `base_sel` is 0. For any other `base_sel` it is bits [5:0] of the 64-bit sum `base_val + disp`. All operations use this full 6-bit count (0..63).
- R2: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low otherwise. `result`, `cc` and `cc_update` are registered at that same edge. While `rst_n` is low, all outputs are 0.
- R3: Rotate left: `op_sel`=0 rotates the low 32 bits of `src` by the count modulo 32. `op_sel`=1 rotates all 64 bits of `src` by the count.
- R4: Logical shifts fill vacated bits with zeros. `op_sel`=2 is a 32-bit left shift, 3 a 64-bit left shift, 4 a 32-bit right shift and 5 a 64-bit right shift. The 32-bit forms act on `src[31:0]` and give a zero low word for counts of 32 or more.
- R5: Arithmetic right shifts fill vacated bits with the sign. `op_sel`=8 uses `src[31:0]` with bit 31 as the sign, and counts of 32 or more give all sign bits. `op_sel`=9 uses all 64 bits with bit 63 as the sign.
- R6: Arithmetic left shifts move every bit below the sign left, fill with zeros, and keep the sign bit of the source. `op_sel`=6 is the 32-bit form (sign at bit 31). `op_sel`=7 is the 64-bit form (sign at bit 63).
- R7: The 32-bit forms (`op_sel` 0, 2, 4, 6, 8) put `dst_old[63:32]` unchanged into `result[63:32]`. The 64-bit forms replace all 64 bits.
- R8: Arithmetic right shifts raise `cc_update` and set `cc` from the signed result of the operation's width: 0 for zero, 1 for negative, 2 for positive.
- R9: Arithmetic left shifts raise `cc_update`. `cc` is 3 when any bit shifted out past the sign position differs from the source sign. Otherwise `cc` follows the zero/negative/positive rule of R8 on the result.
- R10: Rotates and logical shifts give `cc_update`=0 and `cc`=0.
- R11: Any `op_sel` from 10 to 15 returns `dst_old` unchanged in `result`, with `cc_update`=0 and `cc`=0, and still produces the `out_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Starts one operation this cycle |
| op_sel | input | 4 | Operation select (codes in R3..R6, R11) |
| src | input | 64 | Source operand |
| dst_old | input | 64 | Current destination value, whose upper word is kept by the 32-bit forms |
| base_sel | input | 4 | Base register selector; 0 means no base |
| base_val | input | 64 | Base register value |
| disp | input | 12 | Unsigned displacement |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Value to write back |
| cc | output | 2 | Condition code |
| cc_update | output | 1 | Condition code should be written |

## Verification
Every operation has a single latency: the write-back value, the condition code and its update flag all appear together with `out_valid`, on the first rising edge after the strobe. The driver applies inputs on the falling edge and pushes the expected item into a queue. The monitor looks one time step after each rising edge and requires `out_valid` exactly when an item is waiting. It then compares all three results with that item. Any pulse with no item waiting, or any missing pulse, is counted as a failure.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ROTL32 = 4'd0,
    OP_ROTL64 = 4'd1,
    OP_SLL32  = 4'd2,
    OP_SLL64  = 4'd3,
    OP_SRL32  = 4'd4,
    OP_SRL64  = 4'd5,
    OP_SLA32  = 4'd6,
    OP_SLA64  = 4'd7,
    OP_SRA32  = 4'd8,
    OP_SRA64  = 4'd9
  } shop_e;

  // Rotate the low half by count modulo the half width
  function automatic logic [HALF_W-1:0] rotl_half(input logic [HALF_W-1:0] x,
                                                  input logic [AMT_W-1:0] n);
    logic [AMT_W-2:0] r;
    r = n[AMT_W-2:0];
    return (x << r) | (x >> (HALF_W - {27'd0, r}));
  endfunction

  function automatic logic [DATA_W-1:0] rotl_full(input logic [DATA_W-1:0] x,
                                                  input logic [AMT_W-1:0] n);
    return (x << n) | (x >> (DATA_W - {26'd0, n}));
  endfunction

  function automatic logic [HALF_W-1:0] sll_half(input logic [HALF_W-1:0] x,
                                                 input logic [AMT_W-1:0] n);
    return n[AMT_W-1] ? '0 : (x << n[AMT_W-2:0]);
  endfunction

  function automatic logic [HALF_W-1:0] srl_half(input logic [HALF_W-1:0] x,
                                                 input logic [AMT_W-1:0] n);
    return n[AMT_W-1] ? '0 : (x >> n[AMT_W-2:0]);
  endfunction

  function automatic logic [HALF_W-1:0] sra_half(input logic [HALF_W-1:0] x,
                                                 input logic [AMT_W-1:0] n);
    return n[AMT_W-1] ? {HALF_W{x[HALF_W-1]}}
                      : HALF_W'($signed(x) >>> n[AMT_W-2:0]);
  endfunction

  // Arithmetic left shift in a double-width window: {overflow, value}
  function automatic logic [HALF_W:0] sla_half(input logic [HALF_W-1:0] x,
                                               input logic [AMT_W-1:0] n);
    logic [2*DATA_W-1:0] w;
    logic                ov;
    w  = {{(2*DATA_W-HALF_W){x[HALF_W-1]}}, x} << n;
    ov = (w[2*DATA_W-1:HALF_W-1] != {(2*DATA_W-HALF_W+1){x[HALF_W-1]}});
    return {ov, x[HALF_W-1], w[HALF_W-2:0]};
  endfunction

  function automatic logic [DATA_W:0] sla_full(input logic [DATA_W-1:0] x,
                                               input logic [AMT_W-1:0] n);
    logic [2*DATA_W-1:0] w;
    logic                ov;
    w  = {{DATA_W{x[DATA_W-1]}}, x} << n;
    ov = (w[2*DATA_W-1:DATA_W-1] != {(DATA_W+1){x[DATA_W-1]}});
    return {ov, x[DATA_W-1], w[DATA_W-2:0]};
  endfunction

  // Zero / negative / positive code for a signed value
  function automatic logic [1:0] sign_code(input logic is_zero, input logic neg);
    return is_zero ? 2'd0 : (neg ? 2'd1 : 2'd2);
  endfunction

endpackage

// File: rtl/shrot_amount.sv
module shrot_amount #(
  parameter int unsigned DISP_W = 12,
  parameter int unsigned SEL_W  = 4
) (
  input  logic [SEL_W-1:0]              base_sel,
  input  logic [shrot_pkg::DATA_W-1:0]  base_val,
  input  logic [DISP_W-1:0]             disp,
  output logic [shrot_pkg::AMT_W-1:0]   amt
);
  import shrot_pkg::*;

  logic [DATA_W-1:0] eff_addr;
  logic              unused_addr_hi;

  always_comb begin
    if (base_sel == '0) eff_addr = DATA_W'(disp);
    else                eff_addr = base_val + DATA_W'(disp);
  end

  assign amt            = eff_addr[AMT_W-1:0];
  assign unused_addr_hi = ^eff_addr[DATA_W-1:AMT_W];

endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath (
  input  logic [shrot_pkg::OP_W-1:0]    op_sel,
  input  logic [shrot_pkg::DATA_W-1:0]  src,
  input  logic [shrot_pkg::DATA_W-1:0]  dst_old,
  input  logic [shrot_pkg::AMT_W-1:0]   amt,
  output logic [shrot_pkg::DATA_W-1:0]  value,
  output logic                          ovf,
  output logic                          is_half,
  output logic                          legal
);
  import shrot_pkg::*;

  logic [HALF_W-1:0] lo_src;
  logic [HALF_W-1:0] lo_res;
  logic [HALF_W:0]   sla_h;
  logic [DATA_W:0]   sla_f;

  assign lo_src = src[HALF_W-1:0];
  assign sla_h  = sla_half(lo_src, amt);
  assign sla_f  = sla_full(src, amt);
  assign legal  = (op_sel <= OP_SRA64);
  assign is_half = legal && !op_sel[0];

  always_comb begin
    lo_res = '0;
    value  = dst_old;
    ovf    = 1'b0;
    unique case (op_sel)
      OP_ROTL32: lo_res = rotl_half(lo_src, amt);
      OP_SLL32:  lo_res = sll_half(lo_src, amt);
      OP_SRL32:  lo_res = srl_half(lo_src, amt);
      OP_SRA32:  lo_res = sra_half(lo_src, amt);
      OP_SLA32: begin
        lo_res = sla_h[HALF_W-1:0];
        ovf    = sla_h[HALF_W];
      end
      OP_ROTL64: value = rotl_full(src, amt);
      OP_SLL64:  value = src << amt;
      OP_SRL64:  value = src >> amt;
      OP_SRA64:  value = $signed(src) >>> amt;
      OP_SLA64: begin
        value = sla_f[DATA_W-1:0];
        ovf   = sla_f[DATA_W];
      end
      default: ;
    endcase
    if (is_half) value = {dst_old[DATA_W-1:HALF_W], lo_res};
  end

endmodule

// File: rtl/shrot_ccgen.sv
module shrot_ccgen (
  input  logic [shrot_pkg::OP_W-1:0]    op_sel,
  input  logic [shrot_pkg::DATA_W-1:0]  value,
  input  logic                          ovf,
  input  logic                          is_half,
  output logic [1:0]                    cc,
  output logic                          cc_upd
);
  import shrot_pkg::*;

  logic arith;
  logic zero_w;
  logic neg_w;

  assign arith  = (op_sel == OP_SLA32) || (op_sel == OP_SLA64) ||
                  (op_sel == OP_SRA32) || (op_sel == OP_SRA64);
  assign zero_w = is_half ? (value[HALF_W-1:0] == '0) : (value == '0);
  assign neg_w  = is_half ? value[HALF_W-1] : value[DATA_W-1];

  always_comb begin
    cc_upd = arith;
    cc     = 2'd0;
    if (arith) cc = ovf ? 2'd3 : sign_code(zero_w, neg_w);
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int unsigned DISP_W = 12,
  parameter int unsigned SEL_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [shrot_pkg::OP_W-1:0]    op_sel,
  input  logic [shrot_pkg::DATA_W-1:0]  src,
  input  logic [shrot_pkg::DATA_W-1:0]  dst_old,
  input  logic [SEL_W-1:0]              base_sel,
  input  logic [shrot_pkg::DATA_W-1:0]  base_val,
  input  logic [DISP_W-1:0]             disp,
  output logic                          out_valid,
  output logic [shrot_pkg::DATA_W-1:0]  result,
  output logic [1:0]                    cc,
  output logic                          cc_update
);
  import shrot_pkg::*;

  logic [AMT_W-1:0]  amt_w;
  logic [DATA_W-1:0] value_w;
  logic              ovf_w;
  logic              is_half_w;
  logic              legal_w;
  logic [1:0]        cc_w;
  logic              cc_upd_w;

  shrot_amount #(.DISP_W(DISP_W), .SEL_W(SEL_W)) u_amount (
    .base_sel (base_sel),
    .base_val (base_val),
    .disp     (disp),
    .amt      (amt_w)
  );

  shrot_datapath u_datapath (
    .op_sel  (op_sel),
    .src     (src),
    .dst_old (dst_old),
    .amt     (amt_w),
    .value   (value_w),
    .ovf     (ovf_w),
    .is_half (is_half_w),
    .legal   (legal_w)
  );

  shrot_ccgen u_ccgen (
    .op_sel  (op_sel),
    .value   (value_w),
    .ovf     (ovf_w),
    .is_half (is_half_w),
    .cc      (cc_w),
    .cc_upd  (cc_upd_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      cc        <= 2'd0;
      cc_update <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= value_w;
        cc        <= cc_w;
        cc_update <= cc_upd_w;
      end
    end
  end

endmodule

// File: rtl/shrot_unit_checker.sv
module shrot_unit_checker (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_valid,
  input logic [shrot_pkg::OP_W-1:0]    op_sel,
  input logic [shrot_pkg::DATA_W-1:0]  src,
  input logic [shrot_pkg::DATA_W-1:0]  dst_old,
  input logic                          out_valid,
  input logic [shrot_pkg::DATA_W-1:0]  result,
  input logic [1:0]                    cc,
  input logic                          cc_update,
  input logic                          ovf_w,
  input logic                          legal_w
);
  import shrot_pkg::*;

  logic op_half, op_sla, op_quiet;
  assign op_half  = legal_w && !op_sel[0];
  assign op_sla   = (op_sel == OP_SLA32) || (op_sel == OP_SLA64);
  assign op_quiet = (op_sel <= OP_SRL64);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_upper_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_half) |=> (result[63:32] == $past(dst_old[63:32])));
  assert_sign_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_SLA64) |=> (result[63] == $past(src[63])));
  assert_overflow_cc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sla && ovf_w) |=> (cc_update && cc == 2'd3));
  assert_cc3_only_sla_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cc == 2'd3) |-> $past(op_sla));
  assert_no_cc_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_quiet) |=> (!cc_update && cc == 2'd0));
  assert_illegal_passthru_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !legal_w) |=> (result == $past(dst_old) && !cc_update));

endmodule

bind shrot_unit shrot_unit_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .src       (src),
  .dst_old   (dst_old),
  .out_valid (out_valid),
  .result    (result),
  .cc        (cc),
  .cc_update (cc_update),
  .ovf_w     (ovf_w),
  .legal_w   (legal_w)
);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;

  typedef struct {
    logic [63:0] res;
    logic [1:0]  cc;
    logic        upd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op_sel = '0;
  logic [63:0] src = '0, dst_old = '0, base_val = '0;
  logic [3:0]  base_sel = '0;
  logic [11:0] disp = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [1:0]  cc;
  logic        cc_update;

  int checks = 0;
  int failures = 0;
  bit mon_on = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src(src), .dst_old(dst_old), .base_sel(base_sel), .base_val(base_val),
    .disp(disp), .out_valid(out_valid), .result(result), .cc(cc),
    .cc_update(cc_update)
  );

  // ---------------- reference model, bit by bit ----------------
  function automatic logic [63:0] ref_shl(logic [63:0] x, int n, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) if (i - n >= 0) r[i] = x[i-n];
    return r;
  endfunction

  function automatic logic [63:0] ref_shr(logic [63:0] x, int n, int w, logic f);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = (i + n < w) ? x[i+n] : f;
    return r;
  endfunction

  function automatic logic [63:0] ref_rot(logic [63:0] x, int n, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[(i + n) % w] = x[i];
    return r;
  endfunction

  function automatic logic [1:0] ref_code(logic [63:0] v, int w);
    if (ref_shl(v, 0, w) == 64'd0) return 2'd0;
    return v[w-1] ? 2'd1 : 2'd2;
  endfunction

  function automatic string ref_tag(logic [3:0] op);
    case (op)
      4'd0: return "R3 R7 R10";   4'd1: return "R3 R10";
      4'd2, 4'd4: return "R4 R7 R10";
      4'd3, 4'd5: return "R4 R10";
      4'd6: return "R6 R7 R9";    4'd7: return "R6 R9";
      4'd8: return "R5 R7 R8";    4'd9: return "R5 R8";
      default: return "R11";
    endcase
  endfunction

  function automatic exp_t ref_model(logic [3:0] op, logic [63:0] s, logic [63:0] d,
                                     logic [3:0] bs, logic [63:0] bv, logic [11:0] dp);
    exp_t e;
    logic [63:0] sum, v;
    logic signed [127:0] big, lim;
    int n, w;
    sum = bv + {52'd0, dp};
    n = (bs == 4'd0) ? int'(dp[5:0]) : int'(sum[5:0]);
    w = op[0] ? 64 : 32;
    v = '0;
    e.cc = 2'd0; e.upd = 1'b0; e.tag = ref_tag(op);
    case (op)
      4'd0, 4'd1: v = ref_rot(s, n % w, w);
      4'd2, 4'd3: v = ref_shl(s, n, w);
      4'd4, 4'd5: v = ref_shr(s, n, w, 1'b0);
      4'd8, 4'd9: begin
        v = ref_shr(s, n, w, s[w-1]);
        e.upd = 1'b1; e.cc = ref_code(v, w);
      end
      4'd6, 4'd7: begin
        v = ref_shl(s, n, w);
        v[w-1] = s[w-1];
        big = (w == 32) ? 128'($signed(s[31:0])) : 128'($signed(s));
        big = big <<< n;
        lim = 128'sd1 <<< (w - 1);
        e.upd = 1'b1;
        e.cc = ((big >= lim) || (big < -lim)) ? 2'd3 : ref_code(v, w);
      end
      default: ;
    endcase
    if (op > 4'd9)   e.res = d;
    else if (w == 32) e.res = {d[63:32], v[31:0]};
    else             e.res = v;
    return e;
  endfunction

  // ---------------- driver ----------------
  task automatic issue(logic [3:0] op, logic [63:0] s, logic [63:0] d,
                       logic [3:0] bs, logic [63:0] bv, logic [11:0] dp, string extra);
    exp_t e;
    @(negedge clk);
    e = ref_model(op, s, d, bs, bv, dp);
    if (extra != "") e.tag = {extra, " ", e.tag};
    q.push_back(e);
    in_valid = 1'b1; op_sel = op; src = s; dst_old = d;
    base_sel = bs; base_val = bv; disp = dp;
  endtask

  // issue with hand-computed expectations
  task automatic issue_fixed(logic [3:0] op, logic [63:0] s, logic [63:0] d,
                             logic [11:0] dp, logic [63:0] r, logic [1:0] c,
                             logic u, string t);
    exp_t e;
    @(negedge clk);
    e.res = r; e.cc = c; e.upd = u; e.tag = t;
    q.push_back(e);
    in_valid = 1'b1; op_sel = op; src = s; dst_old = d;
    base_sel = 4'd0; base_val = '0; disp = dp;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if (!out_valid || result !== e.res || cc !== e.cc || cc_update !== e.upd) begin
            failures++;
            $display("FAIL %s: got v=%0b res=%h cc=%0d upd=%0b exp v=1 res=%h cc=%0d upd=%0b",
                     e.tag, out_valid, result, cc, cc_update, e.res, e.cc, e.upd);
          end
        end else begin
          checks++;
          if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R2: idle out_valid got %0b exp 0", out_valid);
          end
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int amts[4] = '{0, 31, 32, 63};
    in_valid = 1'b1; op_sel = 4'd3; src = '1; disp = 12'd1;
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || result !== 64'd0 || cc !== 2'd0 || cc_update !== 1'b0) begin
      failures++;
      $display("FAIL R2: reset got v=%0b res=%h cc=%0d upd=%0b exp all zero",
               out_valid, result, cc, cc_update);
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    idle(2);

    // hand-worked corner cases
    issue_fixed(4'd6, 64'h0000_0000_4000_0000, 64'hAAAA_BBBB_0000_0000, 12'd1,
                64'hAAAA_BBBB_0000_0000, 2'd3, 1'b1, "R6 R9 R7 overflow32");
    issue_fixed(4'd9, 64'h8000_0000_0000_0000, 64'd0, 12'd63,
                64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1'b1, "R5 R8 sra63");
    issue_fixed(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 12'd63,
                64'h8000_0000_0000_0000, 2'd1, 1'b1, "R6 R9 sla63 no overflow");
    issue_fixed(4'd0, 64'h1234_5678_8000_0001, 64'hCAFE_F00D_0000_0000, 12'd33,
                64'hCAFE_F00D_0000_0003, 2'd0, 1'b0, "R3 R7 rot mod32");
    issue_fixed(4'd4, 64'h0000_0000_FFFF_FFFF, 64'h1111_2222_3333_4444, 12'd32,
                64'h1111_2222_0000_0000, 2'd0, 1'b0, "R4 srl32 amt32");
    issue_fixed(4'd8, 64'h0000_0000_8000_0000, 64'd0, 12'd40,
                64'h0000_0000_FFFF_FFFF, 2'd1, 1'b1, "R5 R8 sra32 amt40");
    issue_fixed(4'd12, 64'hFFFF, 64'h0123_4567_89AB_CDEF, 12'd5,
                64'h0123_4567_89AB_CDEF, 2'd0, 1'b0, "R11 illegal op");
    issue_fixed(4'd8, 64'h0, 64'd0, 12'd3, 64'h0, 2'd0, 1'b1, "R8 zero result");
    // count from displacement: upper displacement bits dropped
    issue_fixed(4'd3, 64'h1, 64'd0, 12'hFC4, 64'h10, 2'd0, 1'b0, "R1 disp low bits");
    idle(1);
    // base plus displacement, with carry into the low six bits
    issue(4'd5, 64'hF000_0000_0000_0000, 64'd0, 4'd3, 64'h0000_0000_0000_003F,
          12'd5, "R1 base+disp");
    issue(4'd1, 64'h8000_0000_0000_0001, 64'd0, 4'd7, 64'hFFFF_FFFF_FFFF_FFF0,
          12'h013, "R1 base wrap");
    issue(4'd6, 64'h0000_0000_C000_0000, 64'h5555_5555_5555_5555, 4'd0, 64'd0,
          12'd1, "R9 no overflow neg");
    idle(2);

    // every op at the boundary counts
    for (int op = 0; op < 10; op++) begin
      foreach (amts[k]) begin
        issue(4'(op), {$urandom, $urandom}, {$urandom, $urandom}, 4'd0, 64'd0,
              12'(amts[k]), "boundary");
      end
    end
    idle(1);

    // random operands and counts, both address forms
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      issue(op, {$urandom, $urandom}, {$urandom, $urandom},
            ($urandom_range(0, 3) == 0) ? 4'd0 : 4'($urandom_range(1, 15)),
            {$urandom, $urandom}, 12'($urandom), "random");
      if ((i % 37) == 0) idle(1);
    end
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule